// File: doc/BRIEF.md
# Single-Error-Correcting Memory Wrapper with Fault Injection

This block puts a 32-bit single-port word store behind an error-correcting code. Each word is kept with seven check bits. On a read the code corrects any one flipped bit and flags any two flipped bits. A request/response port carries reads, full-word writes and partial writes with byte enables. A partial write is done as a two-cycle read-merge-rewrite. During that sequence the port reports busy, and the old word passes through the same error detection as a read.

For self-test, software can arm a 32-bit data flip mask and a 7-bit check flip mask. The next stored word, from a full write or a merge write-back, is XORed with both masks, and then the masks disarm. Error events carry the failing word address. An uncorrectable event also carries the raw stored data and check bits, so a test can compare them with the corruption it injected.

A global enable turns correction and reporting off. With it off, reads return the stored bits as they are, so memory can be made consistent by reading and rewriting every word before correction is turned on.

Top module: `secded_mem_wrap`

## Requirements
- R1: A read accepted at a clock edge (req_valid high, req_write low, busy low) gives rsp_valid high for exactly the following cycle, with rsp_rdata equal to the last data written to that address. Writes produce no response.
- R2: The check field is an extended Hamming code. Code positions 1..38 are used, and data bit i sits at the i-th position that is not a power of two, counting from position 3 upward. Check bit k (k = 0..5) is the XOR of the data bits whose position has bit k set. Check bit 6 is the XOR of all 32 data bits and check bits 0..5.
- R3: With correction enabled, a stored word with exactly one flipped bit (data or check) reads back corrected, and ce_event is high in the response cycle with err_addr equal to the word address.
- R4: With correction enabled, a stored word with exactly two flipped bits gives ue_event in the response cycle, with err_addr, err_raw_data and err_raw_chk holding the address, stored data and stored check bits. rsp_rdata then carries the stored data unchanged.
- R5: The check bits are computed from the clean write data. The stored data is data XOR data-mask, and the stored check bits are code XOR check-mask.
- R6: A pulse on inj_load arms both masks. They are applied to exactly one stored word and then clear, so later writes store clean words.
- R7: A write whose req_be is not 4'b1111 holds busy high for the one cycle after acceptance, and is written back at the end of that cycle. It replaces only the bytes whose req_be bit (bit b = data bits 8b+7..8b) is set. Requests presented while busy is high are ignored.
- R8: In a partial write, the old word is decoded first. A single flip is corrected before the merge and raises ce_event during the busy cycle. A double flip raises ue_event, and the merge then uses the raw stored bytes.
- R9: With ecc_enable low, reads return the stored data bits without correction, and ce_event and ue_event stay low.
- R10: ce_event and ue_event are never high together. Neither is high outside a response cycle or a busy cycle.
- R11: After reset, busy, rsp_valid, ce_event and ue_event are low, and no fault masks are armed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ecc_enable | input | 1 | Turns correction and error events on |
| inj_load | input | 1 | Arms the two fault masks |
| inj_data_mask | input | 32 | Data bits to flip on the next stored word |
| inj_chk_mask | input | 7 | Check bits to flip on the next stored word |
| req_valid | input | 1 | Request present |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Word address |
| req_be | input | 4 | Byte enables for writes |
| req_wdata | input | 32 | Write data |
| busy | output | 1 | Partial-write sequence in progress; requests ignored |
| rsp_valid | output | 1 | Read data valid |
| rsp_rdata | output | 32 | Read data |
| ce_event | output | 1 | Correctable error seen this cycle |
| ue_event | output | 1 | Uncorrectable error seen this cycle |
| err_addr | output | ADDR_W | Address of the word that raised the event |
| err_raw_data | output | 32 | Stored data bits of that word |
| err_raw_chk | output | 7 | Stored check bits of that word |

## Verification
The checker watches the timing on every cycle. It checks that a read response follows exactly one cycle after acceptance, that a partial write keeps busy high for a single cycle, and that the two event flags stay exclusive, silent outside response and busy cycles, and silent with correction off. It also checks that an event's address matches the request that caused it. Only the bench scenarios can show the contents side: that a single flip anywhere is repaired, that the raw data and check bits reported for a double flip equal the injected corruption on top of the code, that the masks disarm after one store, and that a merge keeps corrected old bytes.

// File: rtl/secded_pkg.sv
package secded_pkg;
  localparam int DW    = 32;
  localparam int HW    = 6;
  localparam int CW    = HW + 1;
  localparam int NPOS  = 38;
  localparam int NB    = DW / 8;
  localparam int WW    = DW + CW;

  typedef enum logic { ST_IDLE = 1'b0, ST_MERGE = 1'b1 } wrap_state_e;

  // code position of data bit i
  function automatic logic [HW-1:0] data_pos(input int i);
    int n;
    data_pos = '0;
    n = 0;
    for (int p = 1; p <= NPOS; p++) begin
      if ((p & (p - 1)) != 0) begin
        if (n == i) data_pos = HW'(p);
        n++;
      end
    end
  endfunction

  function automatic logic [HW-1:0] ham_bits(input logic [DW-1:0] d);
    int n;
    ham_bits = '0;
    n = 0;
    for (int p = 1; p <= NPOS; p++) begin
      if ((p & (p - 1)) != 0) begin
        for (int k = 0; k < HW; k++)
          if (((p >> k) & 1) == 1) ham_bits[k] = ham_bits[k] ^ d[n];
        n++;
      end
    end
  endfunction
endpackage

// File: rtl/secded_enc.sv
module secded_enc
  import secded_pkg::*;
(
  input  logic [DW-1:0] data,
  output logic [CW-1:0] chk
);
  logic [HW-1:0] ham;

  always_comb begin
    ham = ham_bits(data);
    chk = {(^data) ^ (^ham), ham};
  end
endmodule

// File: rtl/secded_dec.sv
module secded_dec
  import secded_pkg::*;
(
  input  logic          en,
  input  logic [DW-1:0] raw_data,
  input  logic [CW-1:0] raw_chk,
  output logic [DW-1:0] fixed_data,
  output logic          ce,
  output logic          ue
);
  logic [HW-1:0] syn;
  logic          par_bad;
  logic          single;

  always_comb begin
    syn     = ham_bits(raw_data) ^ raw_chk[HW-1:0];
    par_bad = ^{raw_data, raw_chk};
    single  = par_bad && (syn <= HW'(NPOS));
    ce      = en && single;
    ue      = en && ((!par_bad && syn != '0) || (par_bad && syn > HW'(NPOS)));
  end

  for (genvar i = 0; i < DW; i++) begin : g_fix
    localparam logic [HW-1:0] POS = data_pos(i);
    assign fixed_data[i] = raw_data[i] ^ (ce && (syn == POS));
  end
endmodule

// File: rtl/secded_store.sv
module secded_store #(
  parameter int ADDR_W = 6,
  parameter int WORD_W = 39
) (
  input  logic              clk,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [WORD_W-1:0] wr_word,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [WORD_W-1:0] rd_word
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [WORD_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_addr] <= wr_word;
  end

  always_ff @(posedge clk) begin
    if (rd_en) rd_word <= mem[rd_addr];
  end
endmodule

// File: rtl/secded_mem_wrap.sv
module secded_mem_wrap
  import secded_pkg::*;
#(
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ecc_enable,
  input  logic              inj_load,
  input  logic [DW-1:0]     inj_data_mask,
  input  logic [CW-1:0]     inj_chk_mask,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [NB-1:0]     req_be,
  input  logic [DW-1:0]     req_wdata,
  output logic              busy,
  output logic              rsp_valid,
  output logic [DW-1:0]     rsp_rdata,
  output logic              ce_event,
  output logic              ue_event,
  output logic [ADDR_W-1:0] err_addr,
  output logic [DW-1:0]     err_raw_data,
  output logic [CW-1:0]     err_raw_chk
);
  localparam logic [NB-1:0] FULL_BE = '1;

  wrap_state_e       state_q, state_d;
  logic              pend_q, pend_d;
  logic [ADDR_W-1:0] addr_q, addr_d;
  logic [DW-1:0]     wdata_q, wdata_d;
  logic [NB-1:0]     be_q, be_d;
  logic [DW-1:0]     dmask_q, dmask_d;
  logic [CW-1:0]     cmask_q, cmask_d;

  logic              accept, is_rd, full_wr, sub_wr, merging, active;
  logic              wr_en;
  logic [ADDR_W-1:0] wr_addr;
  logic [DW-1:0]     wr_src, merged;
  logic [CW-1:0]     wr_code;
  logic [WW-1:0]     rd_word;
  logic [DW-1:0]     dec_data;
  logic              dec_ce, dec_ue;

  // request classification
  always_comb begin
    merging = (state_q == ST_MERGE);
    accept  = req_valid && !merging;
    is_rd   = accept && !req_write;
    full_wr = accept && req_write && (req_be == FULL_BE);
    sub_wr  = accept && req_write && (req_be != FULL_BE);
    active  = pend_q || merging;
  end

  secded_store #(.ADDR_W(ADDR_W), .WORD_W(WW)) u_store (
    .clk     (clk),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_word ({wr_src ^ dmask_q, wr_code ^ cmask_q}),
    .rd_en   (is_rd || sub_wr),
    .rd_addr (req_addr),
    .rd_word (rd_word)
  );

  secded_dec u_dec (
    .en         (ecc_enable),
    .raw_data   (rd_word[WW-1:CW]),
    .raw_chk    (rd_word[CW-1:0]),
    .fixed_data (dec_data),
    .ce         (dec_ce),
    .ue         (dec_ue)
  );

  // byte merge for partial writes
  for (genvar b = 0; b < NB; b++) begin : g_merge
    assign merged[8*b +: 8] = be_q[b] ? wdata_q[8*b +: 8] : dec_data[8*b +: 8];
  end

  always_comb begin
    wr_en   = full_wr || merging;
    wr_addr = merging ? addr_q : req_addr;
    wr_src  = merging ? merged : req_wdata;
  end

  secded_enc u_enc (
    .data (wr_src),
    .chk  (wr_code)
  );

  // next state
  always_comb begin
    state_d = state_q;
    pend_d  = is_rd;
    addr_d  = addr_q;
    wdata_d = wdata_q;
    be_d    = be_q;
    dmask_d = dmask_q;
    cmask_d = cmask_q;
    if (merging) state_d = ST_IDLE;
    if (sub_wr) begin
      state_d = ST_MERGE;
      wdata_d = req_wdata;
      be_d    = req_be;
    end
    if (is_rd || sub_wr) addr_d = req_addr;
    if (inj_load) begin
      dmask_d = inj_data_mask;
      cmask_d = inj_chk_mask;
    end else if (wr_en) begin
      dmask_d = '0;
      cmask_d = '0;
    end
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      pend_q  <= 1'b0;
      addr_q  <= '0;
      wdata_q <= '0;
      be_q    <= '0;
      dmask_q <= '0;
      cmask_q <= '0;
    end else begin
      state_q <= state_d;
      pend_q  <= pend_d;
      addr_q  <= addr_d;
      wdata_q <= wdata_d;
      be_q    <= be_d;
      dmask_q <= dmask_d;
      cmask_q <= cmask_d;
    end
  end

  always_comb begin
    busy         = merging;
    rsp_valid    = pend_q;
    rsp_rdata    = dec_data;
    ce_event     = active && dec_ce;
    ue_event     = active && dec_ue;
    err_addr     = addr_q;
    err_raw_data = rd_word[WW-1:CW];
    err_raw_chk  = rd_word[CW-1:0];
  end
endmodule

// File: rtl/secded_mem_wrap_chk.sv
module secded_mem_wrap_chk #(
  parameter int ADDR_W = 6
) (
  input logic              clk,
  input logic              rst_n,
  input logic              ecc_enable,
  input logic              req_valid,
  input logic              req_write,
  input logic [ADDR_W-1:0] req_addr,
  input logic [3:0]        req_be,
  input logic              busy,
  input logic              rsp_valid,
  input logic              ce_event,
  input logic              ue_event,
  input logic [ADDR_W-1:0] err_addr
);
  p_rsp_follows_read_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !busy && !req_write) |=> rsp_valid);

  p_no_spurious_rsp_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !(req_valid && !busy && !req_write) |=> !rsp_valid);

  p_sub_write_busy_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !busy && req_write && req_be != 4'hF) |=> busy);

  p_busy_one_cycle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> !busy);

  p_no_dual_event_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({ce_event, ue_event}));

  p_no_event_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (ce_event || ue_event) |-> (rsp_valid || busy));

  p_err_addr_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (ce_event || ue_event) |-> (err_addr == $past(req_addr)));

  p_ecc_off_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !ecc_enable |-> !(ce_event || ue_event));
endmodule

bind secded_mem_wrap secded_mem_wrap_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .ecc_enable (ecc_enable),
  .req_valid  (req_valid),
  .req_write  (req_write),
  .req_addr   (req_addr),
  .req_be     (req_be),
  .busy       (busy),
  .rsp_valid  (rsp_valid),
  .ce_event   (ce_event),
  .ue_event   (ue_event),
  .err_addr   (err_addr)
);

// File: tb/tb_secded_mem_wrap.sv
module tb_secded_mem_wrap;
  localparam int AW = 6;

  logic          clk, rst_n, ecc_enable, inj_load;
  logic [31:0]   inj_data_mask;
  logic [6:0]    inj_chk_mask;
  logic          req_valid, req_write;
  logic [AW-1:0] req_addr;
  logic [3:0]    req_be;
  logic [31:0]   req_wdata;
  logic          busy, rsp_valid, ce_event, ue_event;
  logic [31:0]   rsp_rdata, err_raw_data;
  logic [AW-1:0] err_addr;
  logic [6:0]    err_raw_chk;

  secded_mem_wrap #(.ADDR_W(AW)) dut (.*);

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  initial clk = 0;
  always #10 clk = ~clk;

  typedef struct {
    logic [AW-1:0] a;
    logic [31:0]   d;
    int            kind;
    logic [31:0]   rd;
    logic [6:0]    rc;
    string         tag;
  } exp_t;
  exp_t sb[$];

  // bench model
  logic [31:0] lg   [64];
  logic [31:0] st_d [64];
  logic [6:0]  st_c [64];
  logic [31:0] arm_d = '0;
  logic [6:0]  arm_c = '0;

  function automatic logic [6:0] tb_code(input logic [31:0] d);
    logic [5:0] h;
    int n;
    h = '0;
    n = 0;
    for (int p = 3; p <= 38; p++) begin
      if ($countones(p) != 1) begin
        for (int k = 0; k < 6; k++)
          if (p[k]) h[k] = h[k] ^ d[n];
        n++;
      end
    end
    return {(^d) ^ (^h), h};
  endfunction

  function automatic int flips(input logic [AW-1:0] a);
    return $countones({st_d[a] ^ lg[a], st_c[a] ^ tb_code(lg[a])});
  endfunction

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic store(input logic [AW-1:0] a, input logic [31:0] d);
    lg[a]   = d;
    st_d[a] = d ^ arm_d;
    st_c[a] = tb_code(d) ^ arm_c;
    arm_d   = '0;
    arm_c   = '0;
  endtask

  task automatic idle();
    req_valid = 0; req_write = 0; req_be = 4'hF; req_wdata = '0; req_addr = '0;
  endtask

  task automatic arm(input logic [31:0] dm, input logic [6:0] cm);
    @(negedge clk);
    inj_load = 1; inj_data_mask = dm; inj_chk_mask = cm;
    @(negedge clk);
    inj_load = 0; inj_data_mask = '0; inj_chk_mask = '0;
    arm_d = dm; arm_c = cm;
  endtask

  task automatic rd(input logic [AW-1:0] a, input string tag);
    exp_t e;
    int f;
    f = flips(a);
    e.a = a; e.tag = tag; e.rd = st_d[a]; e.rc = st_c[a];
    if (!ecc_enable)  begin e.d = st_d[a]; e.kind = 0; end
    else if (f == 0)  begin e.d = lg[a];   e.kind = 0; end
    else if (f == 1)  begin e.d = lg[a];   e.kind = 1; end
    else              begin e.d = st_d[a]; e.kind = 2; end
    @(negedge clk);
    sb.push_back(e);
    req_valid = 1; req_write = 0; req_addr = a;
    @(negedge clk);
    idle();
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [31:0] d, input logic [3:0] be, input string tag);
    logic [31:0] base, m;
    int f;
    f = flips(a);
    base = (ecc_enable && f <= 1) ? lg[a] : st_d[a];
    for (int b = 0; b < 4; b++) m[8*b +: 8] = be[b] ? d[8*b +: 8] : base[8*b +: 8];
    @(negedge clk);
    req_valid = 1; req_write = 1; req_addr = a; req_be = be; req_wdata = d;
    @(negedge clk);
    if (be != 4'hF) begin
      check({tag, " R7 busy"}, busy, 1);
      check({tag, " R8 ce"}, ce_event, ecc_enable && f == 1);
      check({tag, " R8 ue"}, ue_event, ecc_enable && f >= 2);
      if (ecc_enable && f >= 1) check({tag, " R8 addr"}, err_addr, a);
      // intruding request while busy must be ignored (R7)
      req_addr = a ^ 6'd1; req_be = 4'hF; req_wdata = 32'hDEAD_BEEF;
      @(negedge clk);
      check({tag, " R7 busy drop"}, busy, 0);
    end
    store(a, (be == 4'hF) ? d : m);
    idle();
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_n && !done) begin
      if (rsp_valid) begin
        if (sb.size() == 0) check("R1 unexpected response", 1, 0);
        else begin
          exp_t e;
          e = sb.pop_front();
          check({e.tag, " rdata"}, rsp_rdata, e.d);
          check({e.tag, " ce"}, ce_event, e.kind == 1);
          check({e.tag, " ue"}, ue_event, e.kind == 2);
          if (e.kind != 0) check({e.tag, " err_addr"}, err_addr, e.a);
          if (e.kind == 2) begin
            check({e.tag, " R4 raw data"}, err_raw_data, e.rd);
            check({e.tag, " R4/R2 raw chk"}, err_raw_chk, e.rc);
          end
        end
      end else if (!busy) begin
        check("R10 idle events", {ce_event, ue_event}, 0);
      end
    end
  end

  initial begin
    #4000000;
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog expired");
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    rst_n = 0; ecc_enable = 1; inj_load = 0; inj_data_mask = '0; inj_chk_mask = '0;
    idle();
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check("R11 busy", busy, 0);
    check("R11 rsp_valid", rsp_valid, 0);
    check("R11 events", {ce_event, ue_event}, 0);

    // R1 basic traffic
    for (int i = 0; i < 8; i++) wr(AW'(i), 32'h1357_9BDF * (i + 1) ^ 32'hA5A5_0F0F, 4'hF, "R1 init");
    wr(6'd40, 32'h0000_0000, 4'hF, "R1 zero");
    wr(6'd41, 32'hFFFF_FFFF, 4'hF, "R1 ones");
    for (int i = 0; i < 8; i++) rd(AW'(i), "R1 read");
    rd(6'd40, "R1 zero read");
    rd(6'd41, "R1 ones read");
    // R11: masks clear after reset, so reads above were clean

    // R4/R5/R2 double flips
    arm(32'h0002_0008, 7'h00);
    wr(6'd10, 32'hCAFE_F00D, 4'hF, "R5 dd");
    rd(6'd10, "R4 two data bits");
    arm(32'h0, 7'h21);
    wr(6'd11, 32'h0BAD_CAFE, 4'hF, "R5 cc");
    rd(6'd11, "R4 two check bits");
    arm(32'h8000_0000, 7'h40);
    wr(6'd12, 32'h1234_5678, 4'hF, "R5 dc");
    rd(6'd12, "R4 data plus parity");

    // R6 masks disarmed
    wr(6'd13, 32'h5555_AAAA, 4'hF, "R6 clean");
    rd(6'd13, "R6 after injection");

    // R3 single flips
    arm(32'h0000_0200, 7'h00);
    wr(6'd14, 32'h0F0F_F0F0, 4'hF, "R3 d");
    rd(6'd14, "R3 single data");
    arm(32'h0, 7'h40);
    wr(6'd15, 32'h7777_1111, 4'hF, "R3 p");
    rd(6'd15, "R3 single overall");
    arm(32'h0, 7'h04);
    wr(6'd16, 32'h8888_2222, 4'hF, "R3 h");
    rd(6'd16, "R3 single check");

    // R7 partial writes and ignored intrusions
    wr(6'd2, 32'h0000_AB00, 4'b0010, "R7 byte1");
    rd(6'd2, "R7 merged byte");
    rd(6'd3, "R7 neighbour intact");
    wr(6'd4, 32'hBEEF_0000, 4'b1100, "R7 half");
    rd(6'd4, "R7 merged half");
    rd(6'd5, "R7 neighbour intact");

    // R8 merge over corrupted words
    arm(32'h0010_0000, 7'h00);
    wr(6'd20, 32'h4242_4242, 4'hF, "R8 prep");
    wr(6'd20, 32'h0000_0099, 4'b0001, "R8 ce merge");
    rd(6'd20, "R8 corrected merge");
    arm(32'h0000_0003, 7'h00);
    wr(6'd22, 32'h6161_6161, 4'hF, "R8 prep2");
    wr(6'd22, 32'h7700_0000, 4'b1000, "R8 ue merge");
    rd(6'd22, "R8 after ue merge");

    // R9 correction off, then read-rewrite init
    arm(32'h0000_0C00, 7'h00);
    wr(6'd30, 32'h3C3C_3C3C, 4'hF, "R9 prep");
    arm(32'h0001_0000, 7'h00);
    wr(6'd31, 32'h9999_6666, 4'hF, "R9 prep");
    @(negedge clk); ecc_enable = 0;
    rd(6'd30, "R9 raw double");
    rd(6'd31, "R9 raw single");
    wr(6'd30, st_d[30], 4'hF, "R9 rewrite");
    @(negedge clk); ecc_enable = 1;
    rd(6'd30, "R9 after rewrite");

    repeat (3) @(negedge clk);
    check("R1 scoreboard drained", sb.size(), 0);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule